// File: doc/BRIEF.md
# Two-Wire Register-Access Slave

This block is a serial two-wire (I2C) target that gives an external controller read and write access to a bank of 8-bit control registers, each selected by an 8-bit register pointer. SCL and SDA are brought into the system clock domain through two-flop synchronisers. Their edges, and the START, repeated-START and STOP conditions, are detected from the synchronised levels. The slave never drives SCL, never stretches the clock and never acts as a controller. It pulls SDA low through an output-enable pin, which the pad ring turns into an open-drain driver.

The slave answers only to the 7-bit device address 0101101.

- **Write:** the controller sends the device address with R/W = 0, a register pointer byte and one data byte. The slave acknowledges each of these bytes. It then issues one write strobe to the register bank, carrying the pointer and the data.
- **Read:** the controller first writes the pointer. It then sends a repeated START and the device address with R/W = 1. The slave issues one read strobe, captures the selected register and shifts it out MSB first. The controller ends the byte with a NACK and a STOP.

The register bank is a small internal array. Its address, write data and strobes are also brought out as outputs so that the register-side traffic can be observed.

Top module: `i2c_reg_slave`

## Requirements
- R1: After reset, `sda_oe_o` is 0, `reg_we_o` and `reg_re_o` are 0, and every register reads back as 0x00.
- R2: A byte whose upper seven bits are 0101101 is acknowledged by holding `sda_oe_o` at 1 for the whole ninth SCL clock. Bit 0 of that byte selects the direction: 0 means write, 1 means read.
- R3: When the address byte does not match, the slave acknowledges neither that byte nor any later one. It does not drive SDA and raises no strobe until the next START.
- R4: In a write transaction, the register pointer byte and the data byte, each sent MSB first, are both acknowledged. Exactly one `reg_we_o` pulse of one system clock follows, with `reg_addr_o` equal to the pointer and `reg_wdata_o` equal to the data.
- R5: A read transaction (pointer write, repeated START, address with bit 0 = 1) produces one `reg_re_o` pulse. It then shifts out the register selected by the pointer, MSB first, one bit per SCL clock.
- R6: `sda_oe_o` changes only while the synchronised SCL is low.
- R7: A START seen in any state aborts the transfer in progress and returns the slave to address reception. A STOP seen in any state returns it to idle. Either one releases SDA, and an aborted byte never produces a write strobe.
- R8: There is no auto-increment. A second data byte in the same write transaction is not acknowledged and is not stored, and the register after the pointer is left unchanged.
- R9: Pointer values at or above the bank depth (16 by default) are acknowledged and strobed like any other. Writes to such a pointer are dropped, reads from it return 0x00, and writes there do not alias onto any register inside the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| reg_addr_o | output | 8 | Register pointer presented to the bank |
| reg_wdata_o | output | 8 | Data for a register write |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_re_o | output | 1 | One-cycle register read strobe |

## Verification
Every action of the slave is registered three system clocks after the SCL pin edge that triggers it: two synchroniser stages, then one edge-compare cycle. This applies to each change of `sda_oe_o` and to each strobe. A write strobe therefore appears three clocks after the SCL fall that ends the eighth data bit. An acknowledge or a data bit is on the bus three clocks after the preceding SCL fall. The bench holds each SCL phase for 20 clocks and samples SDA in the middle of the high phase, well after that window. Strobes are compared by a monitor on the falling system clock edge, against a queue filled by the transaction tasks. A change of `sda_oe_o` while the bench holds SCL high is flagged at once.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  // Protocol engine states
  typedef enum logic [3:0] {
    ST_IDLE,     // bus idle, waiting for START
    ST_DEVADDR,  // shifting in device address + direction bit
    ST_DEVACK,   // driving ACK for the device address
    ST_REGADDR,  // shifting in register pointer
    ST_REGACK,   // driving ACK for the pointer
    ST_WDATA,    // shifting in write data
    ST_WACK,     // driving ACK for the data byte
    ST_RDATA,    // shifting out read data
    ST_IGNORE    // not addressed / transfer finished, wait for START or STOP
  } slv_state_e;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int NBITS  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] async_i,
  output logic [NBITS-1:0] lvl_o,
  output logic [NBITS-1:0] rise_o,
  output logic [NBITS-1:0] fall_o
);

  genvar b;
  generate
    for (b = 0; b < NBITS; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic              prev_q;

      // Bus lines idle high, so the chain resets to 1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '1;
          prev_q  <= 1'b1;
        end else begin
          chain_q <= {chain_q[STAGES-2:0], async_i[b]};
          prev_q  <= chain_q[STAGES-1];
        end
      end

      assign lvl_o[b]  = chain_q[STAGES-1];
      assign rise_o[b] = chain_q[STAGES-1] & ~prev_q;
      assign fall_o[b] = ~chain_q[STAGES-1] & prev_q;
    end
  endgenerate

endmodule

// File: rtl/i2cs_regbank.sv
module i2cs_regbank #(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int NREGS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  output logic [DW-1:0] rdata_o
);

  localparam int IW = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [DW-1:0] mem_q [NREGS];
  logic          in_range;
  logic [IW-1:0] idx;

  assign in_range = (int'(addr_i) < NREGS);
  assign idx      = addr_i[IW-1:0];

  genvar r;
  generate
    for (r = 0; r < NREGS; r++) begin : g_reg
      logic wr_en;
      assign wr_en = we_i && in_range && (int'(idx) == r);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mem_q[r] <= '0;
        end else if (wr_en) begin
          mem_q[r] <= wdata_i;
        end
      end
    end
  endgenerate

  // Out-of-range pointers read as zero
  assign rdata_o = in_range ? mem_q[idx] : '0;

  // R9: a write to an out-of-range pointer leaves the low-index alias untouched
  assert_oob_write_dropped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && !in_range) |=> $stable(mem_q[$past(idx)]));

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int          AW       = 8,
  parameter int          DW       = 8,
  parameter logic [6:0]  DEV_ADDR = 7'b0101101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_lvl_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          sda_lvl_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          we_o,
  output logic          re_o,
  output logic          sda_oe_o
);

  localparam int BW = $clog2(DW);
  localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

  slv_state_e    state_q, state_d;
  logic [BW-1:0] cnt_q, cnt_d;
  logic          full_q, full_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [DW-1:0] tx_q, tx_d;
  logic          rw_q, rw_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic [DW-1:0] wd_q, wd_d;
  logic          oe_q, oe_d;
  logic          we_q, we_d;
  logic          re_q, re_d;

  logic          rx_state;

  assign rx_state = (state_q == ST_DEVADDR) || (state_q == ST_REGADDR) ||
                    (state_q == ST_WDATA);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    full_d  = full_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    rw_d    = rw_q;
    ptr_d   = ptr_q;
    wd_d    = wd_q;
    oe_d    = oe_q;
    we_d    = 1'b0;
    re_d    = 1'b0;

    if (stop_i) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_i) begin
      state_d = ST_DEVADDR;
      cnt_d   = '0;
      full_d  = 1'b0;
      oe_d    = 1'b0;
    end else begin
      // Bit counting on the sampling edge, shared by receive and transmit
      if (scl_rise_i && (rx_state || state_q == ST_RDATA)) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_BIT) full_d = 1'b1;
        if (rx_state) sh_d = {sh_q[DW-2:0], sda_lvl_i};
      end

      if (scl_fall_i) begin
        unique case (state_q)
          ST_DEVADDR: begin
            if (full_q) begin
              if (sh_q[DW-1:1] == DEV_ADDR) begin
                state_d = ST_DEVACK;
                oe_d    = 1'b1;
                rw_d    = sh_q[0];
                if (sh_q[0]) begin
                  re_d = 1'b1;
                  tx_d = rdata_i;
                end
              end else begin
                state_d = ST_IGNORE;
                oe_d    = 1'b0;
              end
            end
          end
          ST_DEVACK: begin
            cnt_d  = '0;
            full_d = 1'b0;
            if (rw_q) begin
              state_d = ST_RDATA;
              oe_d    = ~tx_q[DW-1];
              tx_d    = {tx_q[DW-2:0], 1'b0};
            end else begin
              state_d = ST_REGADDR;
              oe_d    = 1'b0;
            end
          end
          ST_REGADDR: begin
            if (full_q) begin
              ptr_d   = sh_q[AW-1:0];
              state_d = ST_REGACK;
              oe_d    = 1'b1;
            end
          end
          ST_REGACK: begin
            cnt_d   = '0;
            full_d  = 1'b0;
            state_d = ST_WDATA;
            oe_d    = 1'b0;
          end
          ST_WDATA: begin
            if (full_q) begin
              wd_d    = sh_q;
              we_d    = 1'b1;
              state_d = ST_WACK;
              oe_d    = 1'b1;
            end
          end
          ST_WACK: begin
            state_d = ST_IGNORE;
            oe_d    = 1'b0;
          end
          ST_RDATA: begin
            if (full_q) begin
              state_d = ST_IGNORE;
              oe_d    = 1'b0;
            end else begin
              oe_d = ~tx_q[DW-1];
              tx_d = {tx_q[DW-2:0], 1'b0};
            end
          end
          default: ;
        endcase
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      sh_q    <= '0;
      tx_q    <= '0;
      rw_q    <= 1'b0;
      ptr_q   <= '0;
      wd_q    <= '0;
      oe_q    <= 1'b0;
      we_q    <= 1'b0;
      re_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      full_q  <= full_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      rw_q    <= rw_d;
      ptr_q   <= ptr_d;
      wd_q    <= wd_d;
      oe_q    <= oe_d;
      we_q    <= we_d;
      re_q    <= re_d;
    end
  end

  assign addr_o   = ptr_q;
  assign wdata_o  = wd_q;
  assign we_o     = we_q;
  assign re_o     = re_q;
  assign sda_oe_o = oe_q;

  // R6: the SDA driver only moves after SCL has been seen low
  assert_oe_moves_scl_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !$past(scl_lvl_i));

  // R4: the write strobe is a single-cycle pulse
  assert_we_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |=> !we_q);

  // R3: when not addressed the slave neither drives nor strobes
  assert_ignore_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE || state_q == ST_IDLE) |-> (!oe_q && !we_q && !re_q));

  // R7: START restarts address reception with SDA released
  assert_start_aborts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i) |=> (state_q == ST_DEVADDR && !oe_q));

  // R7: STOP returns to idle
  assert_stop_idles_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (state_q == ST_IDLE && !oe_q));

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter int         AW       = 8,
  parameter int         DW       = 8,
  parameter int         NREGS    = 16,
  parameter int         SYNC_STG = 2,
  parameter logic [6:0] DEV_ADDR = 7'b0101101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_we_o,
  output logic          reg_re_o
);

  localparam int SCL_B = 1;
  localparam int SDA_B = 0;

  // Reset asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [1:0] lvl, rise, fall;
  logic       start_det, stop_det;
  logic [DW-1:0] bank_rdata;

  i2cs_sync #(.NBITS(2), .STAGES(SYNC_STG)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i ({scl_i, sda_i}),
    .lvl_o   (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  // Bus conditions: SDA moves while SCL is high
  assign start_det = lvl[SCL_B] & fall[SDA_B];
  assign stop_det  = lvl[SCL_B] & rise[SDA_B];

  i2cs_engine #(.AW(AW), .DW(DW), .DEV_ADDR(DEV_ADDR)) u_engine (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .scl_lvl_i  (lvl[SCL_B]),
    .scl_rise_i (rise[SCL_B]),
    .scl_fall_i (fall[SCL_B]),
    .sda_lvl_i  (lvl[SDA_B]),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .rdata_i    (bank_rdata),
    .addr_o     (reg_addr_o),
    .wdata_o    (reg_wdata_o),
    .we_o       (reg_we_o),
    .re_o       (reg_re_o),
    .sda_oe_o   (sda_oe_o)
  );

  i2cs_regbank #(.AW(AW), .DW(DW), .NREGS(NREGS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .addr_i  (reg_addr_o),
    .wdata_i (reg_wdata_o),
    .we_i    (reg_we_o),
    .rdata_o (bank_rdata)
  );

  // R1/R4: write and read strobes never coincide
  assert_strobes_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(reg_we_o && reg_re_o));

endmodule

// File: tb/i2c_reg_slave_tb_top.sv
module i2c_reg_slave_tb_top;

  localparam int HALF = 20;        // system clocks per SCL phase
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic sda_oe;
  logic [7:0] reg_addr, reg_wdata;
  logic reg_we, reg_re;

  always #5 clk = ~clk;

  // Open-drain bus: either side may pull low
  assign sda_bus = sda_m & ~sda_oe;

  i2c_reg_slave dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_we_o    (reg_we),
    .reg_re_o    (reg_re)
  );

  int vecs = 0;
  int fails = 0;
  int re_count = 0;
  bit done = 1'b0;
  logic [15:0] exp_wr[$];   // {addr, data} of expected write strobes

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: compares strobes and watches SDA driver timing (R6)
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_we) begin
        if (exp_wr.size() == 0) begin
          check(1'b0, "R3/R8 unexpected write strobe", {reg_addr, reg_wdata}, 0);
        end else begin
          logic [15:0] e;
          e = exp_wr.pop_front();
          check({reg_addr, reg_wdata} == e, "R4 write strobe", {reg_addr, reg_wdata}, e);
        end
      end
      if (reg_re) re_count++;
      if (sda_oe != prev_oe) check(scl_m == 1'b0, "R6 sda driven while scl high", scl_m, 0);
      prev_oe = sda_oe;
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; w(HALF/2);
    scl_m = 1'b1; w(HALF);
    sda_m = 1'b0; w(HALF);
    scl_m = 1'b0; w(HALF/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(HALF/2);
    scl_m = 1'b1; w(HALF);
    sda_m = 1'b1; w(HALF);
  endtask

  task automatic bus_bit(input logic b, output logic smp);
    sda_m = b; w(HALF/2);
    scl_m = 1'b1; w(HALF/2);
    smp = sda_bus; w(HALF/2);
    scl_m = 1'b0; w(HALF/2);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(d[i], s);
    bus_bit(1'b1, s);
    acked = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      d[i] = s;
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    logic k0, k1, k2;
    exp_wr.push_back({a, d});
    bus_start();
    send_byte(8'h5A, k0);
    send_byte(a, k1);
    send_byte(d, k2);
    bus_stop();
    check(k0, "R2 address ack", k0, 1);
    check(k1 && k2, "R4 pointer/data ack", {k1, k2}, 3);
  endtask

  task automatic reg_read(input logic [7:0] a, input logic [7:0] exp, input string req);
    logic k0, k1, k2, s;
    logic [7:0] d;
    int re0;
    bus_start();
    send_byte(8'h5A, k0);
    send_byte(a, k1);
    sda_m = 1'b1; w(HALF/2);          // repeated START
    scl_m = 1'b1; w(HALF);
    sda_m = 1'b0; w(HALF);
    scl_m = 1'b0; w(HALF/2);
    re0 = re_count;
    send_byte(8'h5B, k2);
    recv_byte(d);
    bus_bit(1'b1, s);                 // controller NACK
    bus_stop();
    check(k0 && k1 && k2, "R2 read-phase acks", {k0, k1, k2}, 7);
    check(re_count == re0 + 1, "R5 one read strobe", re_count - re0, 1);
    check(d == exp, req, d, exp);
  endtask

  // Watchdog
  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    logic k;
    logic [7:0] d;
    w(5);
    rst_n = 1'b1;
    w(5);
    // R1: reset state
    check(sda_oe == 1'b0 && reg_we == 1'b0 && reg_re == 1'b0, "R1 reset outputs",
          {sda_oe, reg_we, reg_re}, 0);
    reg_read(8'h03, 8'h00, "R1 register after reset");

    // R4/R5: plain write/read with several patterns
    reg_write(8'h03, 8'hA5);
    reg_read(8'h03, 8'hA5, "R5 read back 0x03");
    reg_write(8'h0F, 8'h3C);
    reg_write(8'h00, 8'h81);
    reg_read(8'h0F, 8'h3C, "R5 read back 0x0F");
    reg_read(8'h00, 8'h81, "R5 read back 0x00");

    // R3: wrong device address, no ack, no strobe, no drive
    bus_start();
    send_byte(8'h58, k);
    check(!k, "R3 foreign address not acked", k, 0);
    send_byte(8'h03, k);
    check(!k, "R3 later byte not acked", k, 0);
    send_byte(8'hFF, k);
    check(sda_oe == 1'b0, "R3 sda released", sda_oe, 0);
    bus_stop();
    reg_read(8'h03, 8'hA5, "R3 register untouched");

    // R8: second data byte ignored, no auto-increment
    exp_wr.push_back({8'h05, 8'h11});
    bus_start();
    send_byte(8'h5A, k);
    send_byte(8'h05, k);
    send_byte(8'h11, k);
    send_byte(8'h22, k);
    check(!k, "R8 extra data byte not acked", k, 0);
    bus_stop();
    reg_read(8'h05, 8'h11, "R8 first byte stored");
    reg_read(8'h06, 8'h00, "R8 next register unchanged");

    // R9: out-of-range pointer
    reg_write(8'h40, 8'h77);
    reg_read(8'h40, 8'h00, "R9 out-of-range reads zero");
    reg_read(8'h00, 8'h81, "R9 no alias onto register 0");

    // R7: START mid-byte aborts, then a full write from that START
    exp_wr.push_back({8'h07, 8'h5A});
    bus_start();
    send_byte(8'h5A, k);
    send_byte(8'h07, k);
    for (int i = 0; i < 4; i++) bus_bit(1'b0, k);
    bus_start();
    send_byte(8'h5A, k);
    check(k, "R7 address acked after restart", k, 1);
    send_byte(8'h07, k);
    send_byte(8'h5A, k);
    bus_stop();
    reg_read(8'h07, 8'h5A, "R7 write after abort");

    // R7: STOP mid-byte aborts without a strobe
    bus_start();
    send_byte(8'h5A, k);
    send_byte(8'h08, k);
    for (int i = 0; i < 3; i++) bus_bit(1'b1, k);
    bus_stop();
    w(10);
    check(sda_oe == 1'b0, "R7 released after stop", sda_oe, 0);
    reg_read(8'h08, 8'h00, "R7 aborted byte not stored");

    w(20);
    check(exp_wr.size() == 0, "R4 all expected writes seen", exp_wr.size(), 0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule